// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of page tables in memory, for 4 KB pages. A translation request is accepted only while the walker is idle. The walker then makes two reads, one after the other, through a memory read port with a request/grant handshake and a data return of any latency. The first read fetches the outer-table entry, which gives the base of a second-level table. The second read fetches the leaf entry, which gives the frame number and the page state bits.

The walker reports the result as a one-cycle response. The response carries either the physical address and the four state bits, or a page-fault flag together with the level at which the walk stopped. A root register, loaded through its own strobe, holds the frame of the outer table. The root value is captured when a walk is accepted, so loading the root affects only walks accepted later.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `reqReady` is 1, and `memReq` and `respValid` are 0.
- R2: The first read of a walk uses address `{root,12'h000} + vaddr[31:22]*4`, where root is the root register value in the cycle the request is accepted.
- R3: The second read uses address `{outer[31:12],12'h000} + vaddr[21:12]*4`, where outer is the word returned by the first read.
- R4: `memReq` stays high with a stable `memAddr` until `memGnt` is seen. After a grant, `memReq` stays low until the data for that read has returned.
- R5: Each entry uses bit 0 as valid and bits 31:12 as the frame or table base. When both entries are valid, `respValid` pulses for one cycle with `respFault`=0, `respPaddr` = {leaf[31:12], vaddr[11:0]}, and `respFlags` = leaf[4:1] (bit 0 permission, bit 1 referenced, bit 2 modified, bit 3 cacheable).
- R6: An outer entry with bit 0 clear ends the walk without a second read and gives `respFault`=1 with `respFaultLevel`=0.
- R7: A leaf entry with bit 0 clear gives `respFault`=1 with `respFaultLevel`=1.
- R8: `reqReady` is high only while idle. A request presented while the walker is busy is ignored and does not change the walk in progress.
- R9: A root load in the same cycle as a request acceptance, or during a walk, does not affect that walk. Walks accepted afterwards use the new root.
- R10: Any number of wait cycles may pass before the grant and before the data return. `memRdValid` is ignored while no read is outstanding.
- R11: After the response cycle the walker is idle again on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rootLoad | input | 1 | Load strobe for the root register |
| rootValue | input | 20 | Frame of the outer table |
| reqValid | input | 1 | Translation request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqReady | output | 1 | Walker idle, request will be taken |
| memReq | output | 1 | Memory read request |
| memAddr | output | 32 | Physical address of the entry being read |
| memGnt | input | 1 | Memory accepts the read request |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 32 | Entry word returned by memory |
| respValid | output | 1 | One-cycle response strobe |
| respFault | output | 1 | Page fault result |
| respFaultLevel | output | 1 | Level of the invalid entry (0 outer, 1 leaf) |
| respPaddr | output | 32 | Translated physical address |
| respFlags | output | 4 | Leaf state bits |

## Verification
Two events can coincide in one cycle: a root load and the acceptance of a request. A root load can also fall while a walk is running, together with a request the busy walker must refuse. The bench drives the load strobe in the same cycle as the request, and in a later run in the middle of a walk alongside a junk request. It judges both cases by the first read address and by the final physical address, which must follow the root in force when the request was taken. A stray data strobe is also sent during a grant wait, and the same checks must show that it was ignored.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int FLAG_LSB = 1;
  localparam int FLAG_W   = 4;
  localparam int VALID_BIT = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ_L1, ST_READ_L2, ST_DONE, ST_FAULT
  } walkState_t;

  typedef struct packed {
    logic takeReq;
    logic takeOuter;
    logic takeInner;
    logic loadRoot;
    logic useInner;
  } dpCtl_t;
endpackage

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   rootLoad,
  input  logic   memGnt,
  input  logic   memRdValid,
  input  logic   entryValid,
  output dpCtl_t ctl,
  output logic   reqReady,
  output logic   memReq,
  output logic   respValid,
  output logic   respFault,
  output logic   respFaultLevel
);
  walkState_t state, nxtState;
  logic issued;
  logic inRead;
  logic rdTake;
  logic faultLevel;

  assign inRead   = (state == ST_READ_L1) || (state == ST_READ_L2);
  assign reqReady = (state == ST_IDLE);
  assign memReq   = inRead && !issued;
  assign rdTake   = inRead && issued && memRdValid;

  always_comb begin
    ctl.takeReq   = reqReady && reqValid;
    ctl.takeOuter = rdTake && (state == ST_READ_L1) && entryValid;
    ctl.takeInner = rdTake && (state == ST_READ_L2) && entryValid;
    ctl.loadRoot  = rootLoad;
    ctl.useInner  = (state == ST_READ_L2);
  end

  always_comb begin
    nxtState = state;
    case (state)
      ST_IDLE:    if (reqValid) nxtState = ST_READ_L1;
      ST_READ_L1: if (rdTake) nxtState = entryValid ? ST_READ_L2 : ST_FAULT;
      ST_READ_L2: if (rdTake) nxtState = entryValid ? ST_DONE : ST_FAULT;
      ST_DONE:    nxtState = ST_IDLE;
      ST_FAULT:   nxtState = ST_IDLE;
      default:    nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      issued     <= 1'b0;
      faultLevel <= 1'b0;
    end else begin
      state <= nxtState;
      if (rdTake) issued <= 1'b0;
      else if (memReq && memGnt) issued <= 1'b1;
      if (rdTake && !entryValid) faultLevel <= (state == ST_READ_L2);
    end
  end

  assign respValid      = (state == ST_DONE) || (state == ST_FAULT);
  assign respFault      = (state == ST_FAULT);
  assign respFaultLevel = faultLevel;
endmodule

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  localparam int FRAME_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [FRAME_W-1:0] rootValue,
  input  logic [ADDR_W-1:0]  reqVaddr,
  input  logic [ADDR_W-1:0]  memRdData,
  output logic               entryValid,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [ADDR_W-1:0]  respPaddr,
  output logic [FLAG_W-1:0]  respFlags
);
  localparam int OUTER_LSB = OFF_W + IDX_W;

  logic [FRAME_W-1:0] rootReg;
  logic [FRAME_W-1:0] baseReg;
  logic [ADDR_W-1:0]  vaReg;
  logic [ADDR_W-1:0]  leafReg;
  logic [IDX_W-1:0]   curIdx;

  assign curIdx = ctl.useInner ? vaReg[OFF_W +: IDX_W] : vaReg[OUTER_LSB +: IDX_W];
  assign memAddr = {baseReg, {OFF_W{1'b0}}} + ADDR_W'({curIdx, 2'b00});
  assign entryValid = memRdData[VALID_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rootReg <= '0;
      baseReg <= '0;
      vaReg   <= '0;
      leafReg <= '0;
    end else begin
      if (ctl.loadRoot) rootReg <= rootValue;
      if (ctl.takeReq) begin
        vaReg   <= reqVaddr;
        baseReg <= rootReg;
      end
      if (ctl.takeOuter) baseReg <= memRdData[ADDR_W-1:OFF_W];
      if (ctl.takeInner) leafReg <= memRdData;
    end
  end

  assign respPaddr = {leafReg[ADDR_W-1:OFF_W], vaReg[OFF_W-1:0]};
  assign respFlags = leafReg[FLAG_LSB +: FLAG_W];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  localparam int FRAME_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rootLoad,
  input  logic [FRAME_W-1:0] rootValue,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqVaddr,
  output logic               reqReady,
  output logic               memReq,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic               memGnt,
  input  logic               memRdValid,
  input  logic [ADDR_W-1:0]  memRdData,
  output logic               respValid,
  output logic               respFault,
  output logic               respFaultLevel,
  output logic [ADDR_W-1:0]  respPaddr,
  output logic [FLAG_W-1:0]  respFlags
);
  dpCtl_t ctl;
  logic   entryValid;

  pt_walker_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rootLoad(rootLoad),
    .memGnt(memGnt), .memRdValid(memRdValid), .entryValid(entryValid),
    .ctl(ctl), .reqReady(reqReady), .memReq(memReq), .respValid(respValid),
    .respFault(respFault), .respFaultLevel(respFaultLevel)
  );

  pt_walker_dp #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rootValue(rootValue),
    .reqVaddr(reqVaddr), .memRdData(memRdData), .entryValid(entryValid),
    .memAddr(memAddr), .respPaddr(respPaddr), .respFlags(respFlags)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memGnt,
  input logic              respValid,
  input logic              respFault
);
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!memReq && !respValid));
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> (memReq && $stable(memAddr)));
  // R4
  one_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memGnt) |=> !memReq);
  // R11
  resp_then_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> (reqReady && !respValid));
  // R6
  fault_in_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    respFault |-> respValid);
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .memReq(memReq),
  .memAddr(memAddr), .memGnt(memGnt), .respValid(respValid),
  .respFault(respFault)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rootLoad = 1'b0;
  logic [19:0] rootValue = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        reqReady, memReq, memGnt = 1'b0, memRdValid = 1'b0;
  logic [31:0] memAddr, memRdData = '0;
  logic        respValid, respFault, respFaultLevel;
  logic [31:0] respPaddr;
  logic [3:0]  respFlags;

  int total = 0;
  int bad = 0;
  logic [31:0] mem [logic [31:0]];
  logic [19:0] modelRoot = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rstN(rstN), .rootLoad(rootLoad), .rootValue(rootValue),
    .reqValid(reqValid), .reqVaddr(reqVaddr), .reqReady(reqReady),
    .memReq(memReq), .memAddr(memAddr), .memGnt(memGnt),
    .memRdValid(memRdValid), .memRdData(memRdData), .respValid(respValid),
    .respFault(respFault), .respFaultLevel(respFaultLevel),
    .respPaddr(respPaddr), .respFlags(respFlags)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] va(input int i1, input int i2, input int off);
    return {i1[9:0], i2[9:0], off[11:0]};
  endfunction

  task automatic walk(input logic [31:0] vaddr, input int gntWait, input int dataWait,
                      input bit rootNow, input logic [19:0] rootNew,
                      input bit poke, input logic [19:0] pokeRoot);
    logic [31:0] addr [1:2];
    logic [31:0] ent [1:2];
    int expReads, level, phase, gw, dw, cyc, grants;
    bit done, expFault, expLvl;
    addr[1] = {modelRoot, 12'h000} + {20'h0, vaddr[31:22], 2'b00};
    ent[1]  = rd(addr[1]);
    addr[2] = {ent[1][31:12], 12'h000} + {20'h0, vaddr[21:12], 2'b00};
    ent[2]  = rd(addr[2]);
    expFault = !ent[1][0] || !ent[2][0];
    expLvl   = ent[1][0];
    expReads = ent[1][0] ? 2 : 1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R8", "ready before request", 32'(reqReady), 32'd1);
    reqValid = 1'b1;
    reqVaddr = vaddr;
    if (rootNow) begin
      rootLoad = 1'b1; rootValue = rootNew; modelRoot = rootNew;  // R9 same cycle
    end
    level = 1; phase = 0; gw = 0; dw = 0; cyc = 0; grants = 0; done = 0;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
      reqValid = 1'b0; rootLoad = 1'b0; memGnt = 1'b0;
      memRdValid = 1'b0; memRdData = '0;
      chk(reqReady == 1'b0, "R8", "busy ready", 32'(reqReady), 32'd0);
      if (respValid) begin
        done = 1;
        chk(respFault == expFault, expFault ? (expLvl ? "R7" : "R6") : "R5",
            "fault flag", 32'(respFault), 32'(expFault));
        chk(grants == expReads, "R6", "read count", grants, expReads);
        if (expFault)
          chk(respFaultLevel == expLvl, expLvl ? "R7" : "R6", "fault level",
              32'(respFaultLevel), 32'(expLvl));
        else begin
          chk(respPaddr == {ent[2][31:12], vaddr[11:0]}, "R5", "paddr",
              respPaddr, {ent[2][31:12], vaddr[11:0]});
          chk(respFlags == ent[2][4:1], "R5", "flags", 32'(respFlags), 32'(ent[2][4:1]));
        end
      end else begin
        if (phase == 0) begin
          if (memReq) begin
            chk(level <= expReads, "R6", "extra read", level, expReads);
            chk(memAddr == addr[level], level == 1 ? "R2" : "R3", "entry addr",
                memAddr, addr[level]);
            if (gw == gntWait) begin
              memGnt = 1'b1; phase = 1; dw = 0; grants++;
            end else begin
              gw++;
              if (poke && level == 1) begin
                memRdValid = 1'b1; memRdData = 32'h0;  // R10 stray data
              end
            end
          end
        end else begin
          chk(memReq == 1'b0, "R4", "no reissue", 32'(memReq), 32'd0);
          dw++;
          if (dw >= dataWait) begin
            memRdValid = 1'b1; memRdData = ent[level];
            phase = 0; gw = 0; level++;
          end
        end
        if (poke && cyc == 2) begin
          reqValid = 1'b1; reqVaddr = 32'hDEAD_BEEF;  // R8 ignored request
          rootLoad = 1'b1; rootValue = pokeRoot; modelRoot = pokeRoot;  // R9 mid-walk
        end
      end
    end
    chk(done, "R10", "walk finished", 32'(done), 32'd1);
    @(negedge clk);
    chk(reqReady == 1'b1, "R11", "idle after response", 32'(reqReady), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mem[32'h0001_0004] = {20'h00020, 12'h001};
    mem[32'h0002_000C] = {20'h12345, 12'h01F};
    mem[32'h0002_0010] = {20'h55555, 12'h01E};
    mem[32'h0001_0FFC] = {20'h00050, 12'h001};
    mem[32'h0005_0FFC] = {20'hFFFFF, 12'h013};
    mem[32'h0003_0004] = {20'h00040, 12'h001};
    mem[32'h0004_000C] = {20'h0ABCD, 12'h00B};
    repeat (3) @(negedge clk);
    rootLoad = 1'b1; rootValue = 20'h00010;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1", "reset ready", 32'(reqReady), 32'd1);
    chk(memReq == 1'b0, "R1", "reset memReq", 32'(memReq), 32'd0);
    chk(respValid == 1'b0, "R1", "reset respValid", 32'(respValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1", "idle after reset", 32'(reqReady), 32'd1);
    modelRoot = 20'h00010;
    @(negedge clk);
    rootLoad = 1'b0;
    walk(va(1, 3, 12'hABC), 0, 1, 0, 0, 0, 0);
    walk(va(1, 3, 12'h123), 3, 5, 0, 0, 1, 20'h00010);
    walk(va(2, 0, 0), 1, 2, 0, 0, 0, 0);
    walk(va(1, 4, 12'h010), 0, 3, 0, 0, 0, 0);
    walk(va(1023, 1023, 12'hFFF), 2, 1, 0, 0, 0, 0);
    walk(va(1, 3, 12'h005), 0, 1, 1, 20'h00030, 0, 0);
    walk(va(1, 3, 12'h007), 1, 4, 0, 0, 0, 0);
    walk(va(1, 3, 12'h321), 2, 2, 0, 0, 1, 20'h00010);
    walk(va(1, 3, 12'h456), 0, 1, 0, 0, 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule